// File: doc/BRIEF.md
# Iterative Waveform Update Sequencer

This block paces the playback of a single stored waveform toward a D/A converter. After a trigger, it issues a one-cycle update strobe at a fixed programmable spacing in clock cycles. With each strobe it presents the address of the sample to be converted. When the last sample of the waveform has been issued, the address returns to zero and the waveform starts again. This repeats for a programmed number of iterations, or without end when that number is zero. An optional idle gap can be placed between iterations.

Generation starts either directly on the trigger or after a programmed start delay. When the run ends normally, the block can either wait for a further trigger or stay halted until reset. A software stop request ends a run in one of three ways, chosen by a stop-mode code:

- at once;
- after the waveform in progress completes;
- after the iteration set in progress completes.

A `done` pulse marks every end of generation. The sample buffer and the converter itself are outside this block. The system must program the spacing so that the update rate stays within what the converter accepts.

Top module: `wave_seq`

## Requirements
- R1: While reset is active, and after it is released, `upd_o`, `busy_o` and `done_o` are low and `addr_o` is zero. Whenever `busy_o` is low, `addr_o` is zero.
- R2: In post-trigger mode (`dly_en_i` low, or `trig_dly_i` zero), a `trig_i` sampled high while idle makes `busy_o` and `upd_o` high in the next cycle, with `addr_o` equal to 0.
- R3: Within a waveform, successive strobes are `interval_i` cycles apart, or 1 cycle apart when `interval_i` is 0. `addr_o` rises by one per strobe and goes back to 0 after sample `wave_len_i`-1. A `wave_len_i` of 0 stands for 2^ADDR_W samples.
- R4: In delay-trigger mode (`dly_en_i` high and `trig_dly_i` = D > 0), the first strobe comes D cycles later than it would in post-trigger mode.
- R5: When `iter_cnt_i` = N > 0, a run produces exactly N × length strobes and then ends. When `iter_cnt_i` = 0, the run never ends by itself.
- R6: When `gap_i` = G > 0, the last strobe of one iteration and the first strobe of the next are `interval_i` + G cycles apart.
- R7: Every end of generation raises `done_o` for exactly one cycle. `busy_o` is low in that same cycle.
- R8: While busy, triggers are ignored. After a normal end, a new trigger restarts generation only if `retrig_en_i` is high. Otherwise the block stays halted until reset.
- R9: `stop_mode_i` 2'b00 (and 2'b11) stops at once. A `stop_req_i` sampled while busy makes `busy_o` low and `done_o` high in the next cycle.
- R10: With `stop_mode_i` 2'b01, generation continues until the strobe of the last sample of the current waveform, then ends.
- R11: With `stop_mode_i` 2'b10, generation continues until the iteration set in progress completes. With `iter_cnt_i` = 0, it ends at the end of the current waveform instead.
- R12: After a run has been ended by a stop request, triggers are ignored until reset, even with `retrig_en_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (timebase) |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Start trigger, sampled on the clock |
| stop_req_i | input | 1 | Software stop request |
| interval_i | input | CNT_W | Cycles between updates |
| wave_len_i | input | ADDR_W | Samples per waveform (0 = 2^ADDR_W) |
| iter_cnt_i | input | ITER_W | Iterations per run (0 = endless) |
| gap_i | input | CNT_W | Idle cycles added between iterations |
| trig_dly_i | input | CNT_W | Start delay in cycles |
| dly_en_i | input | 1 | Selects delay-trigger mode |
| retrig_en_i | input | 1 | Allows restart on later triggers |
| stop_mode_i | input | 2 | Stop behaviour code |
| addr_o | output | ADDR_W | Sample address for the current update |
| upd_o | output | 1 | One-cycle update strobe |
| busy_o | output | 1 | Generation in progress (start delay, playback or gap) |
| done_o | output | 1 | One-cycle end-of-generation pulse |

## Verification
The bench targets the seams between phases, where each kind of error shows up differently:

- **Delay hand-over.** An off-by-one in the start delay shows up as a first strobe one cycle early or late.
- **Gap exit.** A gap that ignores the interval shortens the spacing across iteration boundaries.
- **Address wrap.** A missed wrap makes `addr_o` run past the waveform length.
- **Stop arriving on a final sample.** A stop on the strobe of a waveform's last sample must end the run there. Letting one more waveform play shows up as extra strobes.
- **Endless runs.** In an endless run, the end-of-set stop mode must fall back to the waveform end rather than hang.
- **Triggers outside an armed idle.** Triggers during playback, after a stopped run, or after a finished run without re-trigger must not start anything. An error here appears as strobes where none are due.

// File: rtl/wave_seq_pkg.sv
`timescale 1ns/1ps
package wave_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DELAY = 3'd1,
        ST_RUN   = 3'd2,
        ST_GAP   = 3'd3,
        ST_HALT  = 3'd4
    } seq_state_t;

    localparam logic [1:0] STOP_NOW  = 2'b00;
    localparam logic [1:0] STOP_WAVE = 2'b01;
    localparam logic [1:0] STOP_SET  = 2'b10;
    localparam logic [1:0] STOP_ALT  = 2'b11;

    typedef struct packed {
        seq_state_t st;
        logic       pend;
        logic [1:0] mode;
        logic       done;
    } seq_ctl_t;

endpackage

// File: rtl/wave_seq_tick.sv
`timescale 1ns/1ps
module wave_seq_tick #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    AST_TICK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cnt_q == $past(val_i)); // R3
    AST_TICK_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE); // R3

endmodule

// File: rtl/wave_seq_addr.sv
`timescale 1ns/1ps
module wave_seq_addr #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          step_i,
    input  logic [AW-1:0] len_i,
    output logic [AW-1:0] addr_o,
    output logic          last_o
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] addr_d, addr_q;

    assign last_o = (addr_q == len_i - ONE);

    always_comb begin
        addr_d = addr_q;
        if (clr_i)
            addr_d = '0;
        else if (step_i)
            addr_d = last_o ? '0 : addr_q + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr_o = addr_q;

    AST_ADDR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> addr_o == '0); // R1

endmodule

// File: rtl/wave_seq_iter.sv
`timescale 1ns/1ps
module wave_seq_iter #(
    parameter int IW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          step_i,
    input  logic [IW-1:0] limit_i,
    output logic          last_o
);
    localparam logic [IW-1:0] ONE = IW'(1);

    logic [IW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (step_i)
            cnt_d = cnt_q + ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (limit_i != '0) && (cnt_q == limit_i - ONE);

    AST_ITER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> cnt_q == '0); // R5

endmodule

// File: rtl/wave_seq.sv
`timescale 1ns/1ps
module wave_seq
    import wave_seq_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 10,
    parameter int ITER_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic              stop_req_i,
    input  logic [CNT_W-1:0]  interval_i,
    input  logic [ADDR_W-1:0] wave_len_i,
    input  logic [ITER_W-1:0] iter_cnt_i,
    input  logic [CNT_W-1:0]  gap_i,
    input  logic [CNT_W-1:0]  trig_dly_i,
    input  logic              dly_en_i,
    input  logic              retrig_en_i,
    input  logic [1:0]        stop_mode_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              upd_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam seq_ctl_t CTL_RESET = '{st: ST_IDLE, pend: 1'b0, mode: STOP_NOW, done: 1'b0};

    seq_ctl_t          ctl_d, ctl_q;
    logic              tick_load, tick_zero;
    logic [CNT_W-1:0]  tick_val, iv_m1;
    logic              a_clr, a_step, a_last;
    logic              i_clr, i_step, i_last;
    logic              stop_any, halt_now, infinite, fin;
    logic [1:0]        eff_mode;
    seq_state_t        fin_st;

    assign busy_o   = (ctl_q.st == ST_DELAY) || (ctl_q.st == ST_RUN) || (ctl_q.st == ST_GAP);
    assign upd_o    = (ctl_q.st == ST_RUN) && tick_zero;
    assign done_o   = ctl_q.done;
    assign iv_m1    = (interval_i == '0) ? '0 : interval_i - CNT_ONE;
    assign infinite = (iter_cnt_i == '0);

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.done = 1'b0;
        tick_load = 1'b0;
        tick_val  = '0;
        a_clr     = 1'b0;
        a_step    = 1'b0;
        i_clr     = 1'b0;
        i_step    = 1'b0;
        fin       = 1'b0;
        fin_st    = ST_HALT;

        // latch the first stop request of a run together with its mode
        if (busy_o && stop_req_i && !ctl_q.pend) begin
            ctl_d.pend = 1'b1;
            ctl_d.mode = stop_mode_i;
        end
        stop_any = ctl_q.pend || (busy_o && stop_req_i);
        eff_mode = ctl_q.pend ? ctl_q.mode : stop_mode_i;
        halt_now = stop_any && ((eff_mode == STOP_NOW) || (eff_mode == STOP_ALT));

        case (ctl_q.st)
            ST_IDLE: begin
                if (trig_i) begin
                    a_clr     = 1'b1;
                    i_clr     = 1'b1;
                    tick_load = 1'b1;
                    if (dly_en_i && (trig_dly_i != '0)) begin
                        ctl_d.st = ST_DELAY;
                        tick_val = trig_dly_i - CNT_ONE;
                    end else begin
                        ctl_d.st = ST_RUN;
                    end
                end
            end
            ST_DELAY: begin
                if (halt_now)       fin = 1'b1;
                else if (tick_zero) ctl_d.st = ST_RUN;
            end
            ST_GAP: begin
                if (halt_now) begin
                    fin = 1'b1;
                end else if (tick_zero) begin
                    ctl_d.st  = ST_RUN;
                    tick_load = 1'b1;
                    tick_val  = iv_m1;
                end
            end
            ST_RUN: begin
                if (halt_now) begin
                    fin = 1'b1;
                end else if (tick_zero) begin
                    a_step    = 1'b1;
                    tick_load = 1'b1;
                    tick_val  = iv_m1;
                    if (a_last) begin
                        i_step = 1'b1;
                        if (stop_any && ((eff_mode == STOP_WAVE) ||
                            ((eff_mode == STOP_SET) && (i_last || infinite)))) begin
                            fin = 1'b1;
                        end else if (i_last) begin
                            fin    = 1'b1;
                            fin_st = retrig_en_i ? ST_IDLE : ST_HALT;
                        end else if (gap_i != '0) begin
                            ctl_d.st = ST_GAP;
                            tick_val = gap_i - CNT_ONE;
                        end
                    end
                end
            end
            default: ;
        endcase

        if (fin) begin
            ctl_d.st   = fin_st;
            ctl_d.done = 1'b1;
            ctl_d.pend = 1'b0;
            a_clr      = 1'b1;
            i_clr      = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RESET;
        else        ctl_q <= ctl_d;
    end

    wave_seq_tick #(.W(CNT_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .load_i(tick_load), .val_i(tick_val), .zero_o(tick_zero)
    );

    wave_seq_addr #(.AW(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .clr_i(a_clr), .step_i(a_step),
        .len_i(wave_len_i), .addr_o(addr_o), .last_o(a_last)
    );

    wave_seq_iter #(.IW(ITER_W)) u_iter (
        .clk(clk), .rst_n(rst_n), .clr_i(i_clr), .step_i(i_step),
        .limit_i(iter_cnt_i), .last_o(i_last)
    );

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R7
    AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o); // R7
    AST_UPD_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> busy_o); // R2
    AST_IDLE_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> addr_o == '0); // R1
    AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_o && (addr_o == wave_len_i - 1'b1)) |=> addr_o == '0); // R3
    AST_STOP_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && stop_req_i && (stop_mode_i == STOP_NOW)) |=> !busy_o); // R9
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_HALT) |=> (ctl_q.st == ST_HALT)); // R12

endmodule

// File: tb/test_wave_seq.sv
`timescale 1ns/1ps
module test_wave_seq;
    localparam int CNT_W = 16, ADDR_W = 10, ITER_W = 16;

    logic clk = 1'b0, rst_n = 1'b0, trig = 1'b0, stop_req = 1'b0;
    logic [CNT_W-1:0]  interval = '0, gap = '0, dly = '0;
    logic [ADDR_W-1:0] len = 10'd4;
    logic [ITER_W-1:0] iters = '0;
    logic dly_en = 1'b0, retrig = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [ADDR_W-1:0] addr_o;
    logic upd_o, busy_o, done_o;

    always #4 clk = ~clk;

    wave_seq #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .ITER_W(ITER_W)) i_wave_seq (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .stop_req_i(stop_req),
        .interval_i(interval), .wave_len_i(len), .iter_cnt_i(iters), .gap_i(gap),
        .trig_dly_i(dly), .dly_en_i(dly_en), .retrig_en_i(retrig), .stop_mode_i(mode),
        .addr_o(addr_o), .upd_o(upd_o), .busy_o(busy_o), .done_o(done_o)
    );

    int n_cmp = 0, n_bad = 0;
    string cur_req = "R1";
    int cyc_n = 0, upd_count = 0, done_count = 0;
    int upd_t[$];

    // behavioural reference: 0 idle, 1 waiting (delay or gap), 2 playing, 3 halted
    int ph = 0, tmr = 0, after = 0, smp = 0, reps = 0, smode = 0;
    bit spend = 0, m_done = 0;

    task automatic m_finish(int p);
        ph = p; m_done = 1; spend = 0; smp = 0; reps = 0;
    endtask

    always @(posedge clk) begin
        int ln, iv;
        bit setdone;
        if (!rst_n) begin
            ph = 0; tmr = 0; smp = 0; reps = 0; spend = 0; m_done = 0;
        end else begin
            ln = (len == 0) ? (1 << ADDR_W) : int'(len);
            iv = (interval == 0) ? 1 : int'(interval);
            m_done = 0;
            if (ph == 0) begin
                if (trig) begin
                    smp = 0; reps = 0;
                    if (dly_en && dly != 0) begin ph = 1; tmr = int'(dly) - 1; after = 0; end
                    else begin ph = 2; tmr = 0; end
                end
            end else if (ph == 1 || ph == 2) begin
                if (stop_req && !spend) begin spend = 1; smode = int'(mode); end
                if (spend && (smode == 0 || smode == 3)) m_finish(3);
                else if (ph == 1) begin
                    if (tmr == 0) begin ph = 2; tmr = after; end else tmr--;
                end else if (tmr > 0) tmr--;
                else begin
                    tmr = iv - 1;
                    if (smp == ln - 1) begin
                        smp = 0; reps++;
                        setdone = (iters != 0) && (reps == int'(iters));
                        if (spend && (smode == 1 || (smode == 2 && (setdone || iters == 0))))
                            m_finish(3);
                        else if (setdone) m_finish(retrig ? 0 : 3);
                        else if (gap != 0) begin ph = 1; tmr = int'(gap) - 1; after = iv - 1; end
                    end else smp++;
                end
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        bit e_upd, e_busy;
        cyc_n++;
        e_upd  = (ph == 2) && (tmr == 0);
        e_busy = (ph == 1) || (ph == 2);
        n_cmp++;
        if (upd_o !== e_upd || busy_o !== e_busy || done_o !== m_done || int'(addr_o) != smp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual upd=%b busy=%b done=%b addr=%0d expected upd=%b busy=%b done=%b addr=%0d",
                     cur_req, cyc_n, upd_o, busy_o, done_o, addr_o, e_upd, e_busy, m_done, smp);
        end
        if (upd_o === 1'b1) begin upd_count++; upd_t.push_back(cyc_n); end
        if (done_o === 1'b1) done_count++;
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic chk(bit ok, string tag, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_stats();
        upd_count = 0; done_count = 0; upd_t.delete();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; trig = 1'b0; stop_req = 1'b0;
        cyc(2);
        chk(busy_o == 0 && upd_o == 0 && done_o == 0 && addr_o == 0, "R1 reset outputs",
            int'({busy_o, upd_o, done_o}), 0);
        rst_n = 1'b1;
        cyc(1);
        clear_stats();
    endtask

    task automatic pulse_trig();
        trig = 1'b1; cyc(1); trig = 1'b0;
    endtask

    task automatic pulse_stop(logic [1:0] m);
        mode = m; stop_req = 1'b1; cyc(1); stop_req = 1'b0;
    endtask

    task automatic wait_end(int maxc);
        int k = 0;
        while (busy_o && k < maxc) begin cyc(1); k++; end
        chk(k < maxc, "watchdog wait_end", k, maxc);
        cyc(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state
        cur_req = "R1";
        cyc(1);
        do_reset();

        // R2, R3, R5: post trigger, two iterations
        cur_req = "R2"; interval = 16'd3; len = 10'd4; iters = 16'd2;
        pulse_trig();
        chk(busy_o && upd_o && addr_o == 0, "R2 first strobe", int'({busy_o, upd_o}), 3);
        cur_req = "R5";
        wait_end(500);
        chk(upd_count == 8, "R5 strobe total", upd_count, 8);
        chk(done_count == 1, "R7 done pulses", done_count, 1);
        chk(upd_t[1] - upd_t[0] == 3, "R3 spacing", upd_t[1] - upd_t[0], 3);

        // R8: no retrigger, further triggers ignored
        cur_req = "R8"; clear_stats();
        pulse_trig(); cyc(30);
        chk(upd_count == 0 && !busy_o, "R8 halted after run", upd_count, 0);

        // R4, R6, R8: delay trigger, gap, retrigger
        do_reset();
        cur_req = "R4"; retrig = 1; dly_en = 1; dly = 16'd5; gap = 16'd4;
        iters = 16'd3; len = 10'd3; interval = 16'd2;
        pulse_trig();
        chk(busy_o && !upd_o, "R4 waiting", int'(upd_o), 0);
        cyc(4);
        chk(!upd_o, "R4 not early", int'(upd_o), 0);
        cyc(1);
        chk(upd_o && addr_o == 0, "R4 first strobe after delay", int'(upd_o), 1);
        cur_req = "R6";
        wait_end(500);
        chk(upd_count == 9, "R5 strobe total 3x3", upd_count, 9);
        chk(upd_t[3] - upd_t[2] == 6, "R6 gap spacing", upd_t[3] - upd_t[2], 6);
        chk(upd_t[1] - upd_t[0] == 2, "R3 spacing in waveform", upd_t[1] - upd_t[0], 2);
        cur_req = "R8"; clear_stats();
        pulse_trig();
        wait_end(500);
        chk(upd_count == 9, "R8 retrigger run", upd_count, 9);

        // R9, R12: immediate stop on endless run
        do_reset();
        cur_req = "R9"; dly_en = 0; gap = 0; iters = 0; len = 10'd5; interval = 16'd2; retrig = 1;
        pulse_trig(); cyc(13);
        pulse_stop(2'b00);
        chk(!busy_o && done_o, "R9 immediate stop", int'({busy_o, done_o}), 1);
        cyc(1);
        chk(!done_o, "R7 done one cycle", int'(done_o), 0);
        cur_req = "R12"; clear_stats();
        pulse_trig(); cyc(20);
        chk(upd_count == 0 && !busy_o, "R12 trigger after stop", upd_count, 0);

        // R10: stop at waveform end
        do_reset();
        cur_req = "R10"; iters = 0; len = 10'd4; interval = 16'd1;
        pulse_trig(); cyc(5);
        pulse_stop(2'b01);
        wait_end(500);
        chk(upd_count == 8, "R10 waveform completes", upd_count, 8);
        chk(done_count == 1, "R7 single done", done_count, 1);

        // R11: stop at iteration-set end, finite
        do_reset();
        cur_req = "R11"; iters = 16'd3; len = 10'd3; interval = 16'd2;
        pulse_trig(); cyc(3);
        pulse_stop(2'b10);
        wait_end(500);
        chk(upd_count == 9, "R11 set completes", upd_count, 9);

        // R11: endless set falls back to waveform end
        do_reset();
        iters = 0; len = 10'd3; interval = 16'd1;
        pulse_trig(); cyc(4);
        pulse_stop(2'b10);
        wait_end(500);
        chk(upd_count == 6, "R11 endless run stop", upd_count, 6);

        // R3 interval zero, R8 trigger while busy ignored
        do_reset();
        cur_req = "R3"; iters = 16'd1; len = 10'd6; interval = 16'd0; retrig = 0;
        pulse_trig(); cyc(1);
        pulse_trig();
        wait_end(200);
        chk(upd_count == 6, "R8 busy trigger ignored", upd_count, 6);
        chk(upd_t[5] - upd_t[0] == 5, "R3 interval zero spacing", upd_t[5] - upd_t[0], 5);

        cyc(3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule